// File: doc/BRIEF.md
# Fractional Clock Synthesizer Channel

This block is a single output lane of a multi-lane digital frequency synthesizer. It runs on a fast reference clock and produces a stream of output strobes. The average strobe rate is the reference rate divided by a fractional ratio. That ratio comes from three terms. The first is a 5-bit coarse term and a 15-bit fine term, which together drive a phase accumulator. The second is a power-of-two post-divider. The third is a divide-by-3 stage that can be switched in.

Software writes a 25-bit configuration word into a shadow register at any time. The shadow value does nothing until software raises the program-enable line. That line is resynchronised into the reference domain, and its rising edge copies the whole shadow word into the active copy in one cycle. Because of this, a running clock can be retuned without an intermediate mixed setting.

An active-low standby input and a per-lane reset input each silence the lane. While either is applied, the accumulator and the divider counters are cleared, so the lane restarts from a known phase when it is released. All pins are plain control and status pins, with no valid/ready handshake, because nothing flows through the block as a data stream.

Top module: `fsyn_channel`

## Requirements
- R1: While rst_n is low, out_pulse is 0 and the active configuration is all zero, which makes the lane unprogrammed.
- R2: A write with cfg_we loads only the shadow word. The active configuration changes only on a rising edge of prog_en, after it passes a 2-stage synchroniser. The new setting governs the accumulator from the third reference edge after prog_en is first sampled high.
- R3: Configuration word layout: pe (fine) is bits 14:0, md (coarse) is bits 19:15, sdiv is bits 23:20, and the ÷3 select (ns_bypass) is bit 24.
- R4: The accumulator adds 2^20 each cycle and wraps at (32+md)·2^15+pe, giving one strobe per wrap. The long-run output rate is f_ref·2^20·32 / ((2^20·(32+md)+32·pe)·2^sdiv·ns).
- R5: The post-divider emits one output pulse per 2^sdiv accumulator strobes.
- R6: When bit 24 is 1, the ÷3 stage is bypassed (ns=1). When bit 24 is 0, the lane divides by a further 3 (ns=3).
- R7: If md, pe and sdiv of the active word are all zero, the lane is unprogrammed and emits no pulses, whatever the value of bit 24.
- R8: While standby_n is 0, out_pulse is 0 from the next edge onward, and the accumulator and counters clear. On release, the lane restarts from zero phase.
- R9: While chan_rst is 1, the lane behaves as in R8.
- R10: Holding prog_en high commits only once. Shadow writes made while it stays high have no effect until it falls and rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference (VCO) clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| cfg_we | input | 1 | Load cfg_word into the shadow register |
| cfg_word | input | 25 | Shadow configuration word (layout in R3) |
| prog_en | input | 1 | Program-enable level; its rising edge commits the shadow word |
| standby_n | input | 1 | Active-low standby |
| chan_rst | input | 1 | Per-lane reset, active high |
| out_pulse | output | 1 | Output strobe, one reference cycle wide per output period |

## Verification
Standby and lane reset take effect on out_pulse at the first edge after they are applied. A commit reaches the accumulator three edges after prog_en is first sampled high: two synchroniser edges and one for the active register. An accumulator wrap reaches out_pulse two edges after the edge that produced it, one edge for the wrap register and one for the output register. The bench reference model advances through these same stages at every rising edge and compares out_pulse half a cycle later, so each result is checked in the exact cycle it is due. Window counts of pulses then confirm the long-run ratio from R4 to R6 against the closed-form formula.

// File: rtl/fsyn_pkg.sv
package fsyn_pkg;
  localparam int MD_W   = 5;
  localparam int PE_W   = 15;
  localparam int SD_W   = 4;
  localparam int CFG_W  = 1 + SD_W + MD_W + PE_W;
  localparam int LIM_W  = 1 + MD_W + PE_W;
  localparam int ACC_W  = LIM_W + 1;
  localparam int SCNT_W = (1 << SD_W) - 1;

  typedef struct packed {
    logic            ns_bypass;
    logic [SD_W-1:0] sdiv;
    logic [MD_W-1:0] md;
    logic [PE_W-1:0] pe;
  } fsyn_cfg_t;
endpackage

// File: rtl/fsyn_commit.sv
module fsyn_commit
  import fsyn_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prog_en,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_word,
  output fsyn_cfg_t        act_cfg
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   commit;
  fsyn_cfg_t              shadow_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q <= '0;
        else        sync_q <= prog_en;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], prog_en};
    end
  endgenerate

  assign commit = sync_q[SYNC_STAGES-1] & ~prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= 1'b0;
      shadow_q <= '0;
      act_cfg  <= '0;
    end else begin
      prev_q <= sync_q[SYNC_STAGES-1];
      if (cfg_we) shadow_q <= fsyn_cfg_t'(cfg_word);
      if (commit) act_cfg  <= shadow_q;
    end
  end
endmodule

// File: rtl/fsyn_phase_acc.sv
module fsyn_phase_acc
  import fsyn_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [MD_W-1:0] md,
  input  logic [PE_W-1:0] pe,
  output logic            wrap
);
  localparam logic [ACC_W-1:0] STEP = ACC_W'(1) << (MD_W + PE_W);

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] sum;
  logic [ACC_W-1:0] limit;

  assign limit = ACC_W'({1'b1, md, pe});
  assign sum   = acc_q + STEP;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      wrap  <= 1'b0;
    end else if (!run) begin
      acc_q <= '0;
      wrap  <= 1'b0;
    end else if (sum >= limit) begin
      acc_q <= sum - limit;
      wrap  <= 1'b1;
    end else begin
      acc_q <= sum;
      wrap  <= 1'b0;
    end
  end
endmodule

// File: rtl/fsyn_post_div.sv
module fsyn_post_div
  import fsyn_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            wrap,
  input  logic [SD_W-1:0] sdiv,
  input  logic            ns_bypass,
  output logic            out_pulse
);
  logic [SCNT_W-1:0] scnt_q;
  logic [SCNT_W-1:0] slim;
  logic [1:0]        tcnt_q;
  logic              s_done;

  assign slim   = {SCNT_W{1'b1}} >> (SCNT_W - int'(sdiv));
  assign s_done = wrap && (scnt_q >= slim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scnt_q    <= '0;
      tcnt_q    <= '0;
      out_pulse <= 1'b0;
    end else if (!run) begin
      scnt_q    <= '0;
      tcnt_q    <= '0;
      out_pulse <= 1'b0;
    end else begin
      out_pulse <= 1'b0;
      if (wrap) begin
        if (s_done) begin
          scnt_q <= '0;
          if (ns_bypass) begin
            out_pulse <= 1'b1;
          end else if (tcnt_q >= 2'd2) begin
            tcnt_q    <= '0;
            out_pulse <= 1'b1;
          end else begin
            tcnt_q <= tcnt_q + 2'd1;
          end
        end else begin
          scnt_q <= scnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/fsyn_channel.sv
module fsyn_channel
  import fsyn_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic             prog_en,
  input  logic             standby_n,
  input  logic             chan_rst,
  output logic             out_pulse
);
  fsyn_cfg_t act_cfg;
  logic      programmed;
  logic      run;
  logic      acc_wrap;

  fsyn_commit #(.SYNC_STAGES(SYNC_STAGES)) u_commit (
    .clk(clk), .rst_n(rst_n), .prog_en(prog_en),
    .cfg_we(cfg_we), .cfg_word(cfg_word), .act_cfg(act_cfg)
  );

  // R7: an all-zero md/pe/sdiv set means the lane has not been programmed
  assign programmed = (act_cfg.md != '0) || (act_cfg.pe != '0) || (act_cfg.sdiv != '0);
  assign run        = standby_n && !chan_rst && programmed;

  fsyn_phase_acc u_acc (
    .clk(clk), .rst_n(rst_n), .run(run),
    .md(act_cfg.md), .pe(act_cfg.pe), .wrap(acc_wrap)
  );

  fsyn_post_div u_div (
    .clk(clk), .rst_n(rst_n), .run(run), .wrap(acc_wrap),
    .sdiv(act_cfg.sdiv), .ns_bypass(act_cfg.ns_bypass), .out_pulse(out_pulse)
  );
endmodule

// File: rtl/fsyn_channel_chk.sv
module fsyn_channel_chk
  import fsyn_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             prog_en,
  input logic             standby_n,
  input logic             chan_rst,
  input logic [CFG_W-1:0] act_cfg,
  input logic             wrap,
  input logic             out_pulse
);
  a_r2_commit_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_cfg) |-> $past(prog_en, 2));

  a_r8_standby_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !standby_n |=> !out_pulse);

  a_r9_lane_reset_silent: assert property (@(posedge clk) disable iff (!rst_n)
    chan_rst |=> !out_pulse);

  a_r7_unprogrammed_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (act_cfg[SD_W+MD_W+PE_W-1:0] == '0) |=> !out_pulse);

  a_r5_pulse_from_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    out_pulse |-> $past(wrap));
endmodule

bind fsyn_channel fsyn_channel_chk u_chk (
  .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .standby_n(standby_n),
  .chan_rst(chan_rst), .act_cfg(act_cfg), .wrap(acc_wrap), .out_pulse(out_pulse)
);

// File: tb/fsyn_channel_test.sv
module fsyn_channel_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [24:0] cfg_word = '0;
  logic        prog_en = 1'b0;
  logic        standby_n = 1'b1;
  logic        chan_rst = 1'b0;
  logic        out_pulse;

  int    checks = 0;
  int    errors = 0;
  int    cyc = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  fsyn_channel uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_word(cfg_word),
    .prog_en(prog_en), .standby_n(standby_n), .chan_rst(chan_rst),
    .out_pulse(out_pulse)
  );

  // behavioural reference model, advanced once per rising edge
  bit          m_s1, m_s2, m_s3, m_wrap, m_out;
  logic [24:0] m_sh, m_act;
  longint      m_acc, t_w, t_sum;
  int          m_scnt, m_tcnt, t_md, t_pe, t_sd;
  bit          t_run, t_bp;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_s3 = 0; m_wrap = 0; m_out = 0;
      m_sh = '0; m_act = '0; m_acc = 0; m_scnt = 0; m_tcnt = 0;
    end else begin
      t_pe = int'(m_act[14:0]);
      t_md = int'(m_act[19:15]);
      t_sd = int'(m_act[23:20]);
      t_bp = m_act[24];
      t_run = standby_n && !chan_rst && (t_pe != 0 || t_md != 0 || t_sd != 0);
      if (!t_run) begin
        m_out = 0; m_scnt = 0; m_tcnt = 0;
      end else begin
        m_out = 0;
        if (m_wrap) begin
          if (m_scnt >= (1 << t_sd) - 1) begin
            m_scnt = 0;
            if (t_bp) m_out = 1;
            else if (m_tcnt >= 2) begin m_tcnt = 0; m_out = 1; end
            else m_tcnt++;
          end else m_scnt++;
        end
      end
      if (!t_run) begin
        m_acc = 0; m_wrap = 0;
      end else begin
        t_w = (longint'(32 + t_md) << 15) + t_pe;
        t_sum = m_acc + (64'd1 << 20);
        if (t_sum >= t_w) begin m_acc = t_sum - t_w; m_wrap = 1; end
        else begin m_acc = t_sum; m_wrap = 0; end
      end
      if (m_s2 && !m_s3) m_act = m_sh;
      if (cfg_we) m_sh = cfg_word;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = prog_en;
    end
  end

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (out_pulse !== m_out) begin
        errors++;
        $display("FAIL %s cycle %0d out_pulse actual %0b expected %0b", cur_req, cyc, out_pulse, m_out);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog actual %0d cycles expected fewer", cyc);
      summary();
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_cfg(input int md, input int pe, input int sd, input bit bp);
    cfg_word = {bp, 4'(sd), 5'(md), 15'(pe)};
    cfg_we = 1'b1;
    step(1);
    cfg_we = 1'b0;
  endtask

  task automatic commit();
    prog_en = 1'b1; step(3);
    prog_en = 1'b0; step(3);
  endtask

  task automatic count_pulses(input int n, output int cnt);
    cnt = 0;
    repeat (n) begin
      @(negedge clk);
      if (out_pulse) cnt++;
    end
  endtask

  task automatic check_rate(input string req, input int n, input int md, input int pe,
                            input int sd, input bit bp);
    int  cnt;
    real expv;
    count_pulses(n, cnt);
    expv = real'(n) * 1048576.0 /
           ((real'(32 + md) * 32768.0 + real'(pe)) * real'(1 << sd) * (bp ? 1.0 : 3.0));
    checks++;
    if ((real'(cnt) - expv) > 2.0 || (expv - real'(cnt)) > 2.0) begin
      errors++;
      $display("FAIL %s pulse count actual %0d expected %0.1f", req, cnt, expv);
    end
  endtask

  task automatic check_zero(input string req, input int n);
    int cnt;
    count_pulses(n, cnt);
    checks++;
    if (cnt != 0) begin
      errors++;
      $display("FAIL %s pulse count actual %0d expected 0", req, cnt);
    end
  endtask

  initial begin
    // R1: reset state
    step(3);
    checks++;
    if (out_pulse !== 1'b0) begin
      errors++;
      $display("FAIL R1 out_pulse in reset actual %0b expected 0", out_pulse);
    end
    rst_n = 1'b1;
    step(2);
    check_zero("R1", 40);

    // R2: shadow write alone stays inert
    cur_req = "R2";
    write_cfg(0, 0, 1, 1'b1);
    check_zero("R2", 60);

    // R3/R5: md=0 pe=0 sdiv=1 bypass -> one pulse every 2 cycles
    cur_req = "R3";
    commit();
    check_rate("R3", 400, 0, 0, 1, 1'b1);
    cur_req = "R5";
    write_cfg(0, 0, 4, 1'b1);
    commit();
    check_rate("R5", 1600, 0, 0, 4, 1'b1);

    // R4: coarse and fine terms
    cur_req = "R4";
    write_cfg(16, 0, 0, 1'b1);
    commit();
    check_rate("R4", 600, 16, 0, 0, 1'b1);
    write_cfg(0, 16384, 1, 1'b1);
    commit();
    check_rate("R4", 1300, 0, 16384, 1, 1'b1);
    write_cfg(31, 32767, 2, 1'b1);
    commit();
    check_rate("R4", 2000, 31, 32767, 2, 1'b1);

    // R6: divide-by-3 selected
    cur_req = "R6";
    write_cfg(0, 0, 1, 1'b0);
    commit();
    check_rate("R6", 1200, 0, 0, 1, 1'b0);

    // R2: rewrite shadow while running, old rate holds until commit
    cur_req = "R2";
    write_cfg(10, 100, 3, 1'b1);
    check_rate("R2", 600, 0, 0, 1, 1'b0);
    commit();
    check_rate("R2", 2000, 10, 100, 3, 1'b1);

    // R10: held-high enable commits once
    cur_req = "R10";
    write_cfg(0, 0, 1, 1'b1);
    prog_en = 1'b1; step(4);
    write_cfg(0, 0, 3, 1'b1);
    step(4);
    check_rate("R10", 800, 0, 0, 1, 1'b1);
    prog_en = 1'b0; step(3);
    commit();
    check_rate("R10", 800, 0, 0, 3, 1'b1);

    // R8: standby
    cur_req = "R8";
    standby_n = 1'b0;
    step(1);
    check_zero("R8", 50);
    standby_n = 1'b1;
    check_rate("R8", 800, 0, 0, 3, 1'b1);

    // R9: lane reset
    cur_req = "R9";
    chan_rst = 1'b1;
    step(1);
    check_zero("R9", 50);
    chan_rst = 1'b0;
    step(30);

    // R7: all-zero md/pe/sdiv with divide-by-3 selected -> silent
    cur_req = "R7";
    write_cfg(0, 0, 0, 1'b0);
    commit();
    check_zero("R7", 100);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule